// File: doc/BRIEF.md
# Interrupt and Exception Dispatch Unit

This block picks one event per cycle from four kinds of request: exceptions raised by an execution core, a non-maskable interrupt, deliveries from a local interrupt controller, and a maskable request whose vector comes from an external interrupt controller. It issues the chosen event as an 8-bit vector together with its class (fault, trap, abort or interrupt), whether an error code must be pushed, and whether that code is the fixed value zero. A valid/ready pair carries the result to the consumer, which holds `out_ready` low for as long as it needs the fields.

Two general-purpose pins change role with the local controller enable. With the controller off, pin 0 is a level-sensitive maskable request and pin 1 is an edge-triggered non-maskable input. With it on, a rising edge on either pin delivers the vector programmed for that pin through the local path. Software interrupt messages from the local controller also use the local path. That path accepts only vectors 16 and above. Lower vectors are dropped and raise a sticky flag.

Top module: `intr_dispatch`

## Requirements
- R1: After a synchronous reset, `out_valid`, `xfetch_req` and `illegal_flag` are 0.
- R2: An accepted core exception is issued with `out_src`=0 and this decode. Class codes are 0 fault, 1 trap, 2 abort and 3 interrupt. Vectors 8 and 18 are aborts. Vectors 3 and 4 are traps. Vector 1 is a trap if `exc_db_trap`=1 and a fault otherwise. Vector 2 and every vector of 32 and above are interrupts. All other legal vectors below 32 are faults. `out_has_err` is 1 only for vectors 8, 10, 11, 12, 13, 14 and 17. `out_err_zero` is 1 only for vectors 8 and 17.
- R3: A core exception is taken (`exc_ack`=1 in its cycle) whenever the output slot is empty and no fetch is under way. If its vector is 15 or lies in 21..31, it is dropped and never issued.
- R4: When sources are pending together, they are issued in this order: core exception, non-maskable interrupt, local delivery, maskable fetch. One event is issued per valid/ready transfer.
- R5: While `out_valid`=1 and `out_ready`=0, every output field keeps its value.
- R6: With the controller off, a rising edge on pin 1 issues vector 2, class interrupt, `out_src`=1, without an error code and whatever `irq_en` is. After that, further non-maskable events are held off until a `nmi_done` pulse. One edge seen during the hold is issued after that pulse.
- R7: With the controller off, `irq_en`=1 and pin 0 high, `xfetch_req` rises and stays high until `xfetch_ack`. The event is then issued with vector `xfetch_vec` (any value 0..255), class interrupt, no error code and `out_src`=3. With `irq_en`=0 no fetch starts.
- R8: With the controller on, a rising edge on pin 0 or pin 1 is delivered on the local path with vector `route0_vec` or `route1_vec` (`out_src`=2, class interrupt, no error code). Neither pin then produces a non-maskable or maskable event.
- R9: A local delivery with a vector below 16 is dropped and sets `illegal_flag`. The flag stays set until `illegal_clr`. If a new illegal delivery and `illegal_clr` fall in the same cycle, the flag stays set.
- R10: The local path holds one pending delivery. In a single cycle a message beats pin 1, which beats pin 0. A legal delivery that arrives while one is already pending is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Core exception request, held until acknowledged |
| exc_vec | input | 8 | Core exception vector |
| exc_db_trap | input | 1 | Vector 1 is reported as a trap when set |
| exc_ack | output | 1 | Core exception taken this cycle |
| pin_in | input | 2 | General interrupt pins (role set by `lctl_en`) |
| lctl_en | input | 1 | Local controller enable |
| route0_vec | input | 8 | Vector programmed for pin 0 when enabled |
| route1_vec | input | 8 | Vector programmed for pin 1 when enabled |
| msg_valid | input | 1 | Local controller message strobe |
| msg_vec | input | 8 | Local controller message vector |
| irq_en | input | 1 | Interrupt-enable flag for the maskable request |
| nmi_done | input | 1 | End of non-maskable handler |
| xfetch_req | output | 1 | Vector fetch request to external controller |
| xfetch_ack | input | 1 | External controller answer |
| xfetch_vec | input | 8 | Vector supplied with the answer |
| illegal_clr | input | 1 | Write-one-to-clear of the illegal flag |
| illegal_flag | output | 1 | Sticky illegal local vector flag |
| out_valid | output | 1 | Issued event valid |
| out_ready | input | 1 | Consumer takes the event |
| out_vec | output | 8 | Event vector |
| out_cls | output | 2 | Event class (0 fault, 1 trap, 2 abort, 3 interrupt) |
| out_has_err | output | 1 | Error code must be pushed |
| out_err_zero | output | 1 | Error code is fixed at zero |
| out_src | output | 2 | Source (0 core, 1 non-maskable, 2 local, 3 external fetch) |

## Verification
The contested event is arbitration. In one cycle, a core exception, a non-maskable edge, a local message and a maskable request are raised together while the output slot is empty. The bench expects them to come out in priority order over successive transfers, with the fields frozen while `out_ready` is held low. A second collision pairs a message with a pin 1 edge in the same cycle, and a third lands an illegal delivery on the cycle of `illegal_clr`. In both cases the surviving vector and the final flag state are compared with the values the requirements give.

// File: rtl/intr_pkg.sv
package intr_pkg;

    typedef enum logic [1:0] {
        CLS_FAULT = 2'd0,
        CLS_TRAP  = 2'd1,
        CLS_ABORT = 2'd2,
        CLS_INTR  = 2'd3
    } evt_cls_e;

    typedef enum logic [1:0] {
        SRC_EXC = 2'd0,
        SRC_NMI = 2'd1,
        SRC_LOC = 2'd2,
        SRC_EXT = 2'd3
    } evt_src_e;

    localparam int unsigned VW = 8;
    localparam logic [VW-1:0] NMI_VEC     = 8'd2;
    localparam logic [VW-1:0] ARCH_TOP    = 8'd31;

    typedef struct packed {
        logic [VW-1:0] vec;
        evt_cls_e      cls;
        logic          has_err;
        logic          err_zero;
        evt_src_e      src;
    } evt_t;

    function automatic logic vec_reserved(input logic [VW-1:0] v);
        return (v == 8'd15) || (v >= 8'd21 && v <= ARCH_TOP);
    endfunction

    function automatic logic vec_has_err(input logic [VW-1:0] v);
        case (v)
            8'd8, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd17: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic evt_cls_e vec_class(input logic [VW-1:0] v, input logic db_trap);
        if (v > ARCH_TOP || v == NMI_VEC) return CLS_INTR;
        case (v)
            8'd8, 8'd18: return CLS_ABORT;
            8'd3, 8'd4:  return CLS_TRAP;
            8'd1:        return db_trap ? CLS_TRAP : CLS_FAULT;
            default:     return CLS_FAULT;
        endcase
    endfunction

    function automatic evt_t mk_exc(input logic [VW-1:0] v, input logic db_trap);
        evt_t e;
        e.vec      = v;
        e.cls      = vec_class(v, db_trap);
        e.has_err  = vec_has_err(v);
        e.err_zero = (v == 8'd8) || (v == 8'd17);
        e.src      = SRC_EXC;
        return e;
    endfunction

    function automatic evt_t mk_irq(input logic [VW-1:0] v, input evt_src_e s);
        evt_t e;
        e.vec      = v;
        e.cls      = CLS_INTR;
        e.has_err  = 1'b0;
        e.err_zero = 1'b0;
        e.src      = s;
        return e;
    endfunction

endpackage

// File: rtl/intr_nmi_gate.sv
module intr_nmi_gate (
    input  logic clk,
    input  logic rst,
    input  logic nmi_edge,
    input  logic issue,
    input  logic done,
    output logic ready
);
    logic pend_q;
    logic block_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            block_q <= 1'b0;
        end else begin
            if (issue)    pend_q <= 1'b0;
            if (nmi_edge) pend_q <= 1'b1;
            if (issue)     block_q <= 1'b1;
            else if (done) block_q <= 1'b0;
        end
    end

    assign ready = pend_q && !block_q;
endmodule

// File: rtl/intr_local_rx.sv
module intr_local_rx #(
    parameter int unsigned VW      = 8,
    parameter int unsigned NPIN    = 2,
    parameter int unsigned MIN_VEC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               msg_valid,
    input  logic [VW-1:0]      msg_vec,
    input  logic [NPIN-1:0]    pin_edge,
    input  logic [NPIN*VW-1:0] pin_vecs,
    input  logic               take,
    input  logic               clr,
    output logic               pend,
    output logic [VW-1:0]      pend_vec,
    output logic               illegal
);
    logic          cand_v;
    logic [VW-1:0] cand_vec;
    logic          cand_ok;

    // message first, then the highest-numbered pin
    always_comb begin
        cand_v   = msg_valid;
        cand_vec = msg_vec;
        if (!msg_valid) begin
            for (int i = 0; i < int'(NPIN); i++) begin
                if (pin_edge[i]) begin
                    cand_v   = 1'b1;
                    cand_vec = pin_vecs[i*VW +: VW];
                end
            end
        end
    end

    assign cand_ok = (cand_vec >= VW'(MIN_VEC));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            pend_vec <= '0;
            illegal  <= 1'b0;
        end else begin
            if (take) pend <= 1'b0;
            if (cand_v && cand_ok && !pend) begin
                pend     <= 1'b1;
                pend_vec <= cand_vec;
            end
            if (cand_v && !cand_ok) illegal <= 1'b1;
            else if (clr)           illegal <= 1'b0;
        end
    end
endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
    import intr_pkg::*;
#(
    parameter int unsigned NPIN    = 2,
    parameter int unsigned MIN_LOC = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          exc_valid,
    input  logic [VW-1:0] exc_vec,
    input  logic          exc_db_trap,
    output logic          exc_ack,
    input  logic [1:0]    pin_in,
    input  logic          lctl_en,
    input  logic [VW-1:0] route0_vec,
    input  logic [VW-1:0] route1_vec,
    input  logic          msg_valid,
    input  logic [VW-1:0] msg_vec,
    input  logic          irq_en,
    input  logic          nmi_done,
    output logic          xfetch_req,
    input  logic          xfetch_ack,
    input  logic [VW-1:0] xfetch_vec,
    input  logic          illegal_clr,
    output logic          illegal_flag,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [VW-1:0] out_vec,
    output logic [1:0]    out_cls,
    output logic          out_has_err,
    output logic          out_err_zero,
    output logic [1:0]    out_src
);
    localparam int unsigned PW = NPIN;

    logic [PW-1:0] pin_q;
    logic [PW-1:0] pin_rise;
    logic [PW-1:0] loc_edge;

    generate
        for (genvar g = 0; g < int'(PW); g++) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst) pin_q[g] <= 1'b0;
                else     pin_q[g] <= pin_in[g];
            end
            assign pin_rise[g] = pin_in[g] && !pin_q[g];
            assign loc_edge[g] = lctl_en && pin_rise[g];
        end
    endgenerate

    logic          nmi_edge;
    logic          nmi_rdy;
    logic          ext_req;
    logic          loc_pend;
    logic [VW-1:0] loc_vec;
    logic          slot_free;
    logic          sel_exc, sel_nmi, sel_loc, sel_ext;
    evt_t          evt_q;

    assign nmi_edge = !lctl_en && pin_rise[1];
    assign ext_req  = !lctl_en && pin_in[0] && irq_en;

    assign slot_free = !out_valid && !xfetch_req;
    assign sel_exc   = slot_free && exc_valid;
    assign sel_nmi   = slot_free && !exc_valid && nmi_rdy;
    assign sel_loc   = slot_free && !exc_valid && !nmi_rdy && loc_pend;
    assign sel_ext   = slot_free && !exc_valid && !nmi_rdy && !loc_pend && ext_req;
    assign exc_ack   = sel_exc;

    intr_nmi_gate u_nmi (
        .clk      (clk),
        .rst      (rst),
        .nmi_edge (nmi_edge),
        .issue    (sel_nmi),
        .done     (nmi_done),
        .ready    (nmi_rdy)
    );

    intr_local_rx #(
        .VW      (VW),
        .NPIN    (PW),
        .MIN_VEC (MIN_LOC)
    ) u_loc (
        .clk       (clk),
        .rst       (rst),
        .msg_valid (msg_valid),
        .msg_vec   (msg_vec),
        .pin_edge  (loc_edge),
        .pin_vecs  ({route1_vec, route0_vec}),
        .take      (sel_loc),
        .clr       (illegal_clr),
        .pend      (loc_pend),
        .pend_vec  (loc_vec),
        .illegal   (illegal_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            xfetch_req <= 1'b0;
            evt_q      <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (sel_exc) begin
                if (!vec_reserved(exc_vec)) begin
                    out_valid <= 1'b1;
                    evt_q     <= mk_exc(exc_vec, exc_db_trap);
                end
            end else if (sel_nmi) begin
                out_valid <= 1'b1;
                evt_q     <= mk_irq(NMI_VEC, SRC_NMI);
            end else if (sel_loc) begin
                out_valid <= 1'b1;
                evt_q     <= mk_irq(loc_vec, SRC_LOC);
            end else if (sel_ext) begin
                xfetch_req <= 1'b1;
            end
            if (xfetch_req && xfetch_ack) begin
                xfetch_req <= 1'b0;
                out_valid  <= 1'b1;
                evt_q      <= mk_irq(xfetch_vec, SRC_EXT);
            end
        end
    end

    assign out_vec      = evt_q.vec;
    assign out_cls      = evt_q.cls;
    assign out_has_err  = evt_q.has_err;
    assign out_err_zero = evt_q.err_zero;
    assign out_src      = evt_q.src;
endmodule

// File: rtl/intr_dispatch_chk.sv
module intr_dispatch_chk
    import intr_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          exc_valid,
    input logic          exc_ack,
    input logic          xfetch_req,
    input logic          xfetch_ack,
    input logic          illegal_flag,
    input logic          illegal_clr,
    input logic          out_valid,
    input logic          out_ready,
    input logic [VW-1:0] out_vec,
    input logic [1:0]    out_cls,
    input logic          out_has_err,
    input logic [1:0]    out_src
);
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_cls)
                                     && $stable(out_src) && $stable(out_has_err));

    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        exc_ack |-> exc_valid);

    a_r3_no_reserved: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_src == SRC_EXC |-> !vec_reserved(out_vec));

    a_r6_nmi_shape: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_src == SRC_NMI |-> out_vec == NMI_VEC && out_cls == CLS_INTR && !out_has_err);

    a_r9_loc_floor: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_src == SRC_LOC |-> out_vec >= 8'd16);

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        illegal_flag && !illegal_clr |=> illegal_flag);

    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        xfetch_req && !xfetch_ack |=> xfetch_req);

    a_r4_single_slot: assert property (@(posedge clk) disable iff (rst)
        xfetch_req |-> !out_valid);
endmodule

bind intr_dispatch intr_dispatch_chk u_chk (.*);

// File: tb/sim_intr_dispatch.sv
module sim_intr_dispatch;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       exc_valid = 0, exc_db_trap = 0, exc_ack;
    logic [7:0] exc_vec = 0;
    logic [1:0] pin_in = 0;
    logic       lctl_en = 0, msg_valid = 0, irq_en = 0, nmi_done = 0;
    logic [7:0] route0_vec = 0, route1_vec = 0, msg_vec = 0, xfetch_vec = 0;
    logic       xfetch_req, xfetch_ack = 0, illegal_clr = 0, illegal_flag;
    logic       out_valid, out_ready = 0, out_has_err, out_err_zero;
    logic [7:0] out_vec;
    logic [1:0] out_cls, out_src;

    int checks = 0;
    int failures = 0;

    intr_dispatch u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit ref_rsv(input logic [7:0] v);
        return v == 15 || (v > 20 && v < 32);
    endfunction

    function automatic logic [1:0] ref_cls(input logic [7:0] v, input logic t);
        if (v >= 32) return 2'd3;
        case (v)
            2: return 2'd3;
            8, 18: return 2'd2;
            3, 4: return 2'd1;
            1: return t ? 2'd1 : 2'd0;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic ref_err(input logic [7:0] v);
        return v == 8 || v == 10 || v == 11 || v == 12 || v == 13 || v == 14 || v == 17;
    endfunction

    function automatic logic [13:0] pack_out(input logic v, input logic [7:0] vec, input logic [1:0] c,
                                             input logic e, input logic z, input logic [1:0] s);
        return {v, vec, c, e, z, s};
    endfunction

    task automatic expect_out(input string tag, input logic [7:0] vec, input logic [1:0] c,
                              input logic e, input logic z, input logic [1:0] s);
        logic [13:0] a, x;
        a = pack_out(out_valid, out_vec, out_cls, out_has_err, out_err_zero, out_src);
        x = pack_out(1'b1, vec, c, e, z, s);
        chk(a == x, tag, 32'(a), 32'(x));
    endtask

    // frees the slot; returns at the negedge right after the clearing edge
    task automatic consume();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!out_valid && !xfetch_req && !illegal_flag, "R1 reset",
            {out_valid, xfetch_req, illegal_flag}, 0);

        // R2/R3 random core exceptions
        for (int i = 0; i < 300; i++) begin
            logic [7:0] v;
            logic t;
            v = (i < 32) ? 8'(i) : 8'($urandom_range(0, 255));
            t = 1'($urandom_range(0, 1));
            exc_valid = 1'b1; exc_vec = v; exc_db_trap = t;
            #1;
            chk(exc_ack == 1'b1, "R3 ack", exc_ack, 1);
            @(negedge clk);
            exc_valid = 1'b0;
            if (ref_rsv(v)) begin
                chk(!out_valid, "R3 reserved dropped", out_valid, 0);
            end else begin
                expect_out("R2 decode", v, ref_cls(v, t), ref_err(v), (v == 8 || v == 17), 2'd0);
                consume();
            end
        end

        // R6 non-maskable path, irq_en off
        irq_en = 0; lctl_en = 0;
        pin_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        expect_out("R6 nmi", 8'd2, 2'd3, 1'b0, 1'b0, 2'd1);
        consume();
        pin_in[1] = 1'b0; @(negedge clk);
        pin_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk(!out_valid, "R6 held off", out_valid, 0);
        nmi_done = 1'b1; @(negedge clk); nmi_done = 1'b0;
        @(negedge clk);
        expect_out("R6 after done", 8'd2, 2'd3, 1'b0, 1'b0, 2'd1);
        consume();
        nmi_done = 1'b1; pin_in[1] = 1'b0; @(negedge clk); nmi_done = 1'b0;

        // R7 maskable fetch
        pin_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk(!xfetch_req && !out_valid, "R7 masked", {xfetch_req, out_valid}, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(xfetch_req, "R7 req", xfetch_req, 1);
        repeat (3) @(negedge clk);
        chk(xfetch_req && !out_valid, "R7 req held", {xfetch_req, out_valid}, 2'b10);
        xfetch_ack = 1'b1; xfetch_vec = 8'h05; pin_in[0] = 1'b0;
        @(negedge clk);
        xfetch_ack = 1'b0;
        expect_out("R7 fetched", 8'h05, 2'd3, 1'b0, 1'b0, 2'd3);
        consume();

        // R4 all sources together, R5 hold
        msg_valid = 1'b1; msg_vec = 8'h70;
        exc_valid = 1'b1; exc_vec = 8'd13; exc_db_trap = 1'b0;
        pin_in = 2'b11;
        @(negedge clk);
        msg_valid = 1'b0; exc_valid = 1'b0;
        expect_out("R4 exc first", 8'd13, 2'd0, 1'b1, 1'b0, 2'd0);
        repeat (3) @(negedge clk);
        expect_out("R5 stable", 8'd13, 2'd0, 1'b1, 1'b0, 2'd0);
        consume(); @(negedge clk);
        expect_out("R4 nmi second", 8'd2, 2'd3, 1'b0, 1'b0, 2'd1);
        consume(); @(negedge clk);
        expect_out("R4 local third", 8'h70, 2'd3, 1'b0, 1'b0, 2'd2);
        consume(); @(negedge clk);
        chk(xfetch_req && !out_valid, "R4 fetch last", {xfetch_req, out_valid}, 2'b10);
        xfetch_ack = 1'b1; xfetch_vec = 8'h21; pin_in = 2'b00;
        @(negedge clk);
        xfetch_ack = 1'b0;
        expect_out("R4 fetched", 8'h21, 2'd3, 1'b0, 1'b0, 2'd3);
        consume();
        nmi_done = 1'b1; @(negedge clk); nmi_done = 1'b0;

        // R8 controller enabled
        lctl_en = 1'b1; route1_vec = 8'h40; route0_vec = 8'h05;
        pin_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        expect_out("R8 pin1 routed", 8'h40, 2'd3, 1'b0, 1'b0, 2'd2);
        consume();
        pin_in[0] = 1'b1;
        @(negedge clk);
        chk(illegal_flag, "R9 flag set", illegal_flag, 1);
        repeat (3) @(negedge clk);
        chk(!out_valid && !xfetch_req, "R8 no fetch / R9 dropped", {out_valid, xfetch_req}, 0);
        // R9 set wins over clear
        pin_in = 2'b00; @(negedge clk);
        illegal_clr = 1'b1; msg_valid = 1'b1; msg_vec = 8'h0F;
        @(negedge clk);
        msg_valid = 1'b0; illegal_clr = 1'b0;
        chk(illegal_flag, "R9 set beats clear", illegal_flag, 1);
        illegal_clr = 1'b1; @(negedge clk); illegal_clr = 1'b0;
        chk(!illegal_flag, "R9 cleared", illegal_flag, 0);

        // R10 same-cycle order: message beats pin 1
        route1_vec = 8'h60;
        msg_valid = 1'b1; msg_vec = 8'h50; pin_in[1] = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        @(negedge clk);
        expect_out("R10 msg beats pin", 8'h50, 2'd3, 1'b0, 1'b0, 2'd2);
        consume();
        repeat (2) @(negedge clk);
        chk(!out_valid, "R10 pin lost", out_valid, 0);

        // R10 pending full: second delivery discarded
        msg_valid = 1'b1; msg_vec = 8'h80; @(negedge clk); msg_valid = 1'b0;
        @(negedge clk);
        msg_valid = 1'b1; msg_vec = 8'h81; @(negedge clk); msg_valid = 1'b0;
        msg_valid = 1'b1; msg_vec = 8'h82; @(negedge clk); msg_valid = 1'b0;
        expect_out("R10 first", 8'h80, 2'd3, 1'b0, 1'b0, 2'd2);
        consume(); @(negedge clk);
        expect_out("R10 pending kept", 8'h81, 2'd3, 1'b0, 1'b0, 2'd2);
        consume();
        repeat (2) @(negedge clk);
        chk(!out_valid, "R10 full discarded", out_valid, 0);

        // R1 reset mid-run
        illegal_clr = 1'b0; msg_valid = 1'b1; msg_vec = 8'h01;
        @(negedge clk); msg_valid = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk(!out_valid && !xfetch_req && !illegal_flag, "R1 reset again",
            {out_valid, xfetch_req, illegal_flag}, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule